// File: doc/BRIEF.md
# Infrared Carrier Generator

This block turns the fast oscillator clock into a modulated infrared carrier on one output pin. An 8-bit up-counter steps once per input clock. When it passes 0xFF it restarts from a reload value, which fixes the carrier period at 256 minus that value in input clocks. The output is high from the moment the count reaches a duty compare value until the wrap, and low before that. The block raises no interrupt and produces only the waveform.

Software sets up the carrier through a small write port with four registers. A new reload value waits in a staging buffer and takes effect only at the next wrap, so a frequency change never cuts a carrier cycle short. Two control bits gate the carrier. The run bit starts or freezes the counter, and the carrier bit lets the waveform out. The pin stays low unless both bits are set.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset the counter, the staged and active reload values, the duty value and both control bits are 0, and `carrier_o` is low.
- R2: While the run bit (control register bit 0) is 1, the counter rises by exactly one on each clock edge below 0xFF.
- R3: On the clock edge where a running counter is at 0xFF, the counter loads the staged reload value, and that value becomes the active reload (`reload_o`). The carrier period is therefore 256 minus the reload value, in clocks.
- R4: A write to the reload register (address 1) changes only the staging buffer. `reload_o` keeps its old value until the next wrap.
- R5: While both enables are set, `carrier_o` is high when the counter is at or above the duty value (address 2) and low when it is below. Each period therefore holds 256 minus duty high clocks.
- R6: `carrier_o` is low whenever the run bit (bit 0) or the carrier bit (bit 1) of the control register (address 3) is 0.
- R7: While the run bit is 0, the counter holds its value.
- R8: A write to the counter register (address 0) loads the counter on that edge. It takes priority over both incrementing and wrapping, and it does not promote the staged reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed oscillator clock that drives the counter |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 counter, 1 reload, 2 duty, 3 control |
| wr_data_i | input | 8 | Write data; control uses bits [1:0] |
| cnt_o | output | 8 | Current counter value |
| reload_o | output | 8 | Active reload value |
| carrier_o | output | 1 | Gated carrier output |

## Verification
The assertions assume at most one register write per clock. They also assume `wr_addr_i` and `wr_data_i` are stable and defined while `wr_i` is high, because the counter properties tell a software load apart from a natural step only through the address. The stimulus meets this by changing inputs only on the falling edge, issuing each write as a single-cycle strobe, and clearing the strobe before the next one. Duty values are kept between the reload value and 0xFF, so that the high and low clock counts per period follow directly from R3 and R5.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_DUTY   = 2'd2,
    REG_CTRL   = 2'd3
  } ir_reg_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_CAR_BIT = 1;
  localparam int unsigned CTRL_W       = 2;
endpackage

// File: rtl/ir_reload_buf.sv
module ir_reload_buf #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             wrap_i,
  output logic [WIDTH-1:0] staged_o,
  output logic [WIDTH-1:0] active_o
);
  logic [WIDTH-1:0] staged_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i)   staged_q <= data_i;
      if (wrap_i) active_q <= staged_q;
    end
  end

  assign staged_o = staged_q;
  assign active_o = active_q;
endmodule

// File: rtl/ir_counter.sv
module ir_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q, cnt_d;

  assign wrap_o = run_i && !load_i && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (wrap_o) cnt_d = reload_i;
    else if (run_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ir_regs.sv
module ir_regs
  import ir_carrier_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              duty_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [WIDTH-1:0]  data_i,
  output logic [WIDTH-1:0]  duty_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [WIDTH-1:0]  duty_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (duty_wr_i) duty_q <= data_i;
      if (ctrl_wr_i) ctrl_q <= data_i[CTRL_W-1:0];
    end
  end

  assign duty_o = duty_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ir_duty_out.sv
module ir_duty_out #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] duty_i,
  input  logic             run_i,
  input  logic             car_en_i,
  output logic             carrier_o
);
  logic above_duty;

  assign above_duty = (cnt_i >= duty_i);
  assign carrier_o  = run_i && car_en_i && above_duty;
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  cnt_o,
  output logic [WIDTH-1:0]  reload_o,
  output logic              carrier_o
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [NREG-1:0]   sel;
  logic [WIDTH-1:0]  staged, active, duty, cnt;
  logic [CTRL_W-1:0] ctrl;
  logic              wrap, run, car_en;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign sel[g] = wr_i && (wr_addr_i == ADDR_W'(g));
  end

  assign run    = ctrl[CTRL_RUN_BIT];
  assign car_en = ctrl[CTRL_CAR_BIT];

  ir_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .duty_wr_i(sel[REG_DUTY]),
    .ctrl_wr_i(sel[REG_CTRL]),
    .data_i   (wr_data_i),
    .duty_o   (duty),
    .ctrl_o   (ctrl)
  );

  ir_reload_buf #(.WIDTH(WIDTH)) u_reload (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel[REG_RELOAD]),
    .data_i  (wr_data_i),
    .wrap_i  (wrap),
    .staged_o(staged),
    .active_o(active)
  );

  // the counter restarts from the value being promoted at this wrap
  ir_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .load_i    (sel[REG_COUNT]),
    .load_val_i(wr_data_i),
    .reload_i  (staged),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  ir_duty_out #(.WIDTH(WIDTH)) u_out (
    .cnt_i    (cnt),
    .duty_i   (duty),
    .run_i    (run),
    .car_en_i (car_en),
    .carrier_o(carrier_o)
  );

  assign cnt_o    = cnt;
  assign reload_o = active;
endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk
  import ir_carrier_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [WIDTH-1:0]  cnt_o,
  input logic [WIDTH-1:0]  reload_o,
  input logic              carrier_o,
  input logic              run,
  input logic              car_en
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic cnt_wr;
  assign cnt_wr = wr_i && (wr_addr_i == REG_COUNT);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cnt_wr && cnt_o != CNT_MAX) |=> (cnt_o == WIDTH'($past(cnt_o) + 1'b1))); // R2

  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !cnt_wr && cnt_o == CNT_MAX) |=> (cnt_o == reload_o)); // R3

  AST_ACTIVE_ONLY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run && !cnt_wr && cnt_o == CNT_MAX) |=> $stable(reload_o)); // R4

  AST_GATED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run && car_en) |-> !carrier_o); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr) |=> $stable(cnt_o)); // R7

  AST_NO_RUN_CARRIER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_o |-> run); // R6
endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .wr_addr_i(wr_addr_i),
  .cnt_o    (cnt_o),
  .reload_o (reload_o),
  .carrier_o(carrier_o),
  .run      (run),
  .car_en   (car_en)
);

// File: tb/sim_ir_carrier_gen.sv
module sim_ir_carrier_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] cnt_o, reload_o;
  logic       carrier_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  ir_carrier_gen u0 (.*);

  // {reload, duty, period, high clocks}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'h80, 16'd256, 16'd128},
    {8'hC0, 8'hE0, 16'd64,  16'd32},
    {8'h10, 8'h10, 16'd240, 16'd240},
    {8'hFE, 8'hFF, 16'd2,   16'd1},
    {8'h00, 8'h00, 16'd256, 16'd256},
    {8'h80, 8'hFF, 16'd128, 16'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; commits on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    int hi;
    repeat (3) @(negedge clk_i);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 reload", reload_o, 0);
    chk("R1 carrier", carrier_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", cnt_o, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] r, d;
      int per, high;
      r = VEC[v][47:40]; d = VEC[v][39:32];
      per = int'(VEC[v][31:16]); high = int'(VEC[v][15:0]);
      wr(2'd3, 8'h00);
      wr(2'd1, r);
      wr(2'd0, 8'hFF);
      wr(2'd2, d);
      wr(2'd3, 8'h03);
      @(negedge clk_i);
      chk("R3 restart value", cnt_o, r);
      chk("R3 active reload", reload_o, r);
      hi = 0;
      for (int i = 0; i < per; i++) begin
        if (carrier_o) hi++;
        @(negedge clk_i);
      end
      chk("R5 high clocks", hi, high);
      chk("R3 period", cnt_o, r);
    end

    // R4 staged reload not active until wrap
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h40);
    chk("R4 reload unchanged after write", reload_o, 8'h80);
    wr(2'd0, 8'hFE);
    wr(2'd3, 8'h01);
    chk("R7 held before run", cnt_o, 8'hFE);
    @(negedge clk_i);
    chk("R2 step", cnt_o, 8'hFF);
    chk("R4 still old reload", reload_o, 8'h80);
    @(negedge clk_i);
    chk("R3 wrap to staged", cnt_o, 8'h40);
    chk("R4 promoted", reload_o, 8'h40);

    // R6 gating with duty 0 (raw carrier always high)
    wr(2'd2, 8'h00);
    chk("R6 run only", carrier_o, 0);
    wr(2'd3, 8'h02);
    chk("R6 carrier only", carrier_o, 0);
    wr(2'd3, 8'h00);
    chk("R6 none", carrier_o, 0);
    wr(2'd3, 8'h03);
    chk("R6 both", carrier_o, 1);

    // R7 hold
    wr(2'd3, 8'h00);
    held = cnt_o;
    repeat (5) @(negedge clk_i);
    chk("R7 hold", cnt_o, held);
    chk("R6 low when stopped", carrier_o, 0);

    // R8 counter write beats wrap
    wr(2'd1, 8'h22);
    wr(2'd0, 8'hFE);
    wr(2'd3, 8'h01);
    @(negedge clk_i);
    chk("R2 reach max", cnt_o, 8'hFF);
    wr(2'd0, 8'h33);
    chk("R8 load wins", cnt_o, 8'h33);
    chk("R8 no promote", reload_o, 8'h40);
    @(negedge clk_i);
    chk("R2 step after load", cnt_o, 8'h34);

    // R5 edge at duty boundary
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h50);
    wr(2'd0, 8'h4F);
    wr(2'd3, 8'h03);
    chk("R5 below duty", carrier_o, 0);
    @(negedge clk_i);
    chk("R5 at duty", carrier_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule